// File: doc/BRIEF.md
# Memory Reclaim Address Remapper

This block translates each incoming logical address for a memory controller hub and decides where it goes. Low addresses below the top-of-low-memory boundary go straight to DRAM. The span from that boundary up to 4 GB is the memory-mapped I/O hole, and those addresses go to the I/O target. Above 4 GB, a programmable reclaim window is folded back onto the DRAM that the I/O hole hides. An address in that window goes to DRAM at the top-of-low-memory value plus its distance from the window base. Any other address above 4 GB is DRAM if it lies below the top of installed memory, and unmapped otherwise.

A one-cycle register write port loads five settings: the top of low memory, the top of installed memory, the window base, the window limit and the reclaim enable. All boundaries are held at 1 MB granularity. The block checks the programming and raises a configuration error for illegal settings. While that error is up, no window address is translated.

Each request is accepted with a valid/ready handshake. One cycle later the block returns a registered one-hot target and the translated address.

Top module: `memReclaimRemap`

## Requirements
- R1: After reset, rspValid and cfgErr are 0. The boundary registers, in 1 MB blocks, hold: top of low memory 0xC00, top of memory 0x1000, window base 0x1000, window limit 0x13FF. Reclaim is disabled.
- R2: rspValid is 1 in the cycle after a cycle with reqValid and reqReady both high, and is 0 after any other cycle.
- R3: An address whose block number (bits 35:20) is below top of low memory targets DRAM, with rspAddr equal to reqAddr.
- R4: An address whose block is at or above top of low memory and below 0x1000 (4 GB) targets I/O, with rspAddr equal to reqAddr.
- R5: With reclaim enabled and no configuration error, an address above 4 GB whose block lies in [base, limit] inclusive targets DRAM. Its rspAddr bits 35:20 equal top of low memory plus (block minus base), and bits 19:0 are copied from reqAddr.
- R6: With reclaim enabled, a window address whose translated block would reach 0x1000 or more targets unmapped.
- R7: An address above 4 GB that is outside the window, or any such address while reclaim is disabled, targets DRAM untranslated when its block is below top of memory. Otherwise it targets unmapped.
- R8: cfgErr is 1 exactly when reclaim is enabled and top of low memory has any of its low 6 bits set (not 64 MB aligned), or when base is greater than limit. A top of low memory that is only 1 MB aligned gives no error while reclaim is disabled.
- R9: While cfgErr is 1 and reclaim is enabled, a window address above 4 GB and at or above top of low memory targets unmapped, with rspAddr equal to reqAddr.
- R10: The write port has cfgSel codes 0 top of low memory, 1 top of memory, 2 base, 3 limit, and 4 enable (cfgData bit 0). Other codes change nothing. reqReady is 0 in a cycle with cfgWe high and 1 otherwise. A write takes effect from the next cycle.
- R11: rspTarget is one-hot while rspValid is 1: bit 0 DRAM, bit 1 I/O, bit 2 unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select code |
| cfgData | input | 16 | Write data, in 1 MB blocks |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted this cycle |
| reqAddr | input | 36 | Logical request address |
| rspValid | output | 1 | Registered response valid |
| rspTarget | output | 3 | One-hot target: DRAM, I/O, unmapped |
| rspAddr | output | 36 | Translated physical address |
| cfgErr | output | 1 | Illegal programming flag |

## Verification
A corrupted boundary or enable register first appears as a wrong target or a wrong upper address field. This shows in the very first response whose block number sits between the good and the bad boundary value, one cycle after that request. A bad error flag shows on cfgErr one cycle after the write. Its further effect shows in the next in-window request, which turns from DRAM to unmapped or the reverse. An offset or adder fault shows only in the upper address bits of translated window responses, so the stimulus places addresses at the base, at the limit and at the 4 GB fold-over edge.

// File: rtl/memReclaimPkg.sv
package memReclaimPkg;
  typedef enum logic [2:0] {
    TGT_DRAM  = 3'b001,
    TGT_IO    = 3'b010,
    TGT_UNMAP = 3'b100
  } target_e;

  typedef struct packed {
    logic capture;
    logic xlateOk;
  } ctrlStrobe_t;

  localparam logic [2:0] SEL_TOLM   = 3'd0;
  localparam logic [2:0] SEL_TOPMEM = 3'd1;
  localparam logic [2:0] SEL_BASE   = 3'd2;
  localparam logic [2:0] SEL_LIMIT  = 3'd3;
  localparam logic [2:0] SEL_EN     = 3'd4;
endpackage

// File: rtl/memReclaimCtrl.sv
module memReclaimCtrl
  import memReclaimPkg::*;
#(
  parameter int BLK_W      = 16,
  parameter int ALIGN_BITS = 6,
  parameter logic [BLK_W-1:0] RST_TOLM   = 16'h0C00,
  parameter logic [BLK_W-1:0] RST_TOPMEM = 16'h1000,
  parameter logic [BLK_W-1:0] RST_BASE   = 16'h1000,
  parameter logic [BLK_W-1:0] RST_LIMIT  = 16'h13FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [BLK_W-1:0] cfgData,
  input  logic             reqValid,
  output logic             reqReady,
  output logic [BLK_W-1:0] tolmQ,
  output logic [BLK_W-1:0] topMemQ,
  output logic [BLK_W-1:0] baseQ,
  output logic [BLK_W-1:0] limitQ,
  output logic             enQ,
  output logic             cfgErr,
  output ctrlStrobe_t      strobe
);
  logic misaligned;
  logic inverted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tolmQ   <= RST_TOLM;
      topMemQ <= RST_TOPMEM;
      baseQ   <= RST_BASE;
      limitQ  <= RST_LIMIT;
      enQ     <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_TOLM:   tolmQ   <= cfgData;
        SEL_TOPMEM: topMemQ <= cfgData;
        SEL_BASE:   baseQ   <= cfgData;
        SEL_LIMIT:  limitQ  <= cfgData;
        SEL_EN:     enQ     <= cfgData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    misaligned     = enQ && (|tolmQ[ALIGN_BITS-1:0]);
    inverted       = baseQ > limitQ;
    cfgErr         = misaligned || inverted;
    reqReady       = !cfgWe;
    strobe.capture = reqValid && !cfgWe;
    strobe.xlateOk = enQ && !cfgErr;
  end
endmodule

// File: rtl/memReclaimDatapath.sv
module memReclaimDatapath
  import memReclaimPkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int GRAN_LSB = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [ADDR_W-GRAN_LSB-1:0]  tolm,
  input  logic [ADDR_W-GRAN_LSB-1:0]  topMem,
  input  logic [ADDR_W-GRAN_LSB-1:0]  base,
  input  logic [ADDR_W-GRAN_LSB-1:0]  limit,
  input  logic                        en,
  output logic                        rspValid,
  output logic [2:0]                  rspTarget,
  output logic [ADDR_W-1:0]           rspAddr
);
  localparam int BLK_W = ADDR_W - GRAN_LSB;
  localparam int FOUR_G_SHIFT = 32 - GRAN_LSB;
  localparam logic [BLK_W-1:0] FOUR_G_BLK = {{(BLK_W-1){1'b0}}, 1'b1} << FOUR_G_SHIFT;

  logic [BLK_W-1:0]    blk;
  logic [BLK_W-1:0]    offset;
  logic [BLK_W:0]      foldSum;
  logic                inWin;
  logic                fits;
  target_e             nextTgt;
  logic [ADDR_W-1:0]   nextAddr;

  always_comb begin
    blk      = reqAddr[ADDR_W-1:GRAN_LSB];
    inWin    = (blk >= base) && (blk <= limit);
    offset   = blk - base;
    foldSum  = {1'b0, tolm} + {1'b0, offset};
    fits     = foldSum < {1'b0, FOUR_G_BLK};
    nextAddr = reqAddr;
    if (blk < tolm) begin
      nextTgt = TGT_DRAM;
    end else if (blk < FOUR_G_BLK) begin
      nextTgt = TGT_IO;
    end else if (en && inWin) begin
      if (strobe.xlateOk && fits) begin
        nextTgt  = TGT_DRAM;
        nextAddr = {foldSum[BLK_W-1:0], reqAddr[GRAN_LSB-1:0]};
      end else begin
        nextTgt = TGT_UNMAP;
      end
    end else if (blk < topMem) begin
      nextTgt = TGT_DRAM;
    end else begin
      nextTgt = TGT_UNMAP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspTarget <= '0;
      rspAddr   <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspTarget <= nextTgt;
        rspAddr   <= nextAddr;
      end
    end
  end
endmodule

// File: rtl/memReclaimRemap.sv
module memReclaimRemap
  import memReclaimPkg::*;
#(
  parameter int ADDR_W     = 36,
  parameter int GRAN_LSB   = 20,
  parameter int ALIGN_LSB  = 26,
  parameter int BLK_W      = ADDR_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [BLK_W-1:0]  cfgData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [2:0]        rspTarget,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              cfgErr
);
  localparam int ALIGN_BITS = ALIGN_LSB - GRAN_LSB;

  logic [BLK_W-1:0] tolmQ;
  logic [BLK_W-1:0] topMemQ;
  logic [BLK_W-1:0] baseQ;
  logic [BLK_W-1:0] limitQ;
  logic             enQ;
  ctrlStrobe_t      strobe;

  memReclaimCtrl #(
    .BLK_W(BLK_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady),
    .tolmQ(tolmQ), .topMemQ(topMemQ), .baseQ(baseQ), .limitQ(limitQ), .enQ(enQ),
    .cfgErr(cfgErr), .strobe(strobe)
  );

  memReclaimDatapath #(
    .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .tolm(tolmQ), .topMem(topMemQ), .base(baseQ), .limit(limitQ), .en(enQ),
    .rspValid(rspValid), .rspTarget(rspTarget), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/memReclaimRemapChk.sv
module memReclaimRemapChk #(
  parameter int ADDR_W   = 36,
  parameter int GRAN_LSB = 20,
  parameter int BLK_W    = ADDR_W - GRAN_LSB
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [2:0]        rspTarget,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              cfgErr,
  input logic [BLK_W-1:0]  tolm,
  input logic [BLK_W-1:0]  base,
  input logic [BLK_W-1:0]  limit,
  input logic              en
);
  localparam int FOUR_G_SHIFT = 32 - GRAN_LSB;
  localparam logic [BLK_W-1:0] FOUR_G_BLK = {{(BLK_W-1){1'b0}}, 1'b1} << FOUR_G_SHIFT;

  logic             fire;
  logic [BLK_W-1:0] blk;
  logic             inWin;
  assign fire  = reqValid && reqReady;
  assign blk   = reqAddr[ADDR_W-1:GRAN_LSB];
  assign inWin = (blk >= base) && (blk <= limit);

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> rspValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !rspValid);
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones(rspTarget) == 1));
  a_r3_low_pass: assert property (@(posedge clk) disable iff (!rstN)
    (fire && blk < tolm) |=> (rspTarget == 3'b001 && rspAddr == $past(reqAddr)));
  a_r4_hole_io: assert property (@(posedge clk) disable iff (!rstN)
    (fire && blk >= tolm && blk < FOUR_G_BLK) |=> (rspTarget == 3'b010));
  a_r5_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAddr[GRAN_LSB-1:0] == $past(reqAddr[GRAN_LSB-1:0])));
  a_r9_err_unmap: assert property (@(posedge clk) disable iff (!rstN)
    (fire && cfgErr && en && inWin && blk >= FOUR_G_BLK && blk >= tolm)
      |=> (rspTarget == 3'b100));
endmodule

bind memReclaimRemap memReclaimRemapChk #(
  .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspTarget(rspTarget), .rspAddr(rspAddr), .cfgErr(cfgErr),
  .tolm(tolmQ), .base(baseQ), .limit(limitQ), .en(enQ)
);

// File: tb/memReclaimRemap_tb.sv
module memReclaimRemap_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 36;
  localparam int GRAN = 20;
  localparam int BLK_W = ADDR_W - GRAN;
  localparam logic [BLK_W-1:0] FOURG = 16'h1000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [2:0]        cfgSel = '0;
  logic [BLK_W-1:0]  cfgData = '0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              rspValid;
  logic [2:0]        rspTarget;
  logic [ADDR_W-1:0] rspAddr;
  logic              cfgErr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [BLK_W-1:0] mTolm, mTop, mBase, mLimit;
  logic             mEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  memReclaimRemap u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspTarget(rspTarget), .rspAddr(rspAddr), .cfgErr(cfgErr)
  );

  function automatic logic expErr();
    return (mEn && (mTolm[5:0] != 0)) || (mBase > mLimit);
  endfunction

  function automatic logic [ADDR_W+2:0] expResp(input logic [ADDR_W-1:0] a);
    logic [BLK_W-1:0] b;
    logic [BLK_W:0]   s;
    b = a[ADDR_W-1:GRAN];
    s = {1'b0, mTolm} + {1'b0, b - mBase};
    if (b < mTolm) return {3'b001, a};
    if (b < FOURG) return {3'b010, a};
    if (mEn && b >= mBase && b <= mLimit) begin
      if (!expErr() && s < {1'b0, FOURG}) return {3'b001, s[BLK_W-1:0], a[GRAN-1:0]};
      return {3'b100, a};
    end
    if (b < mTop) return {3'b001, a};
    return {3'b100, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [BLK_W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = d; reqValid = 1'b1;
    #1 check("R10 ready low on write", 64'(reqReady), 64'(0));
    @(negedge clk);
    cfgWe = 1'b0; reqValid = 1'b0;
    check("R2 no response after blocked request", 64'(rspValid), 64'(0));
    case (sel)
      3'd0: mTolm = d;
      3'd1: mTop = d;
      3'd2: mBase = d;
      3'd3: mLimit = d;
      3'd4: mEn = d[0];
      default: ;
    endcase
    check("R8 cfgErr after write", 64'(cfgErr), 64'(expErr()));
  endtask

  task automatic doReq(input string req, input logic [ADDR_W-1:0] a);
    logic [ADDR_W+2:0] e;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    e = expResp(a);
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " R2 rspValid"}, 64'(rspValid), 64'(1));
    check({req, " R11 target"}, 64'(rspTarget), 64'(e[ADDR_W+2:ADDR_W]));
    check({req, " addr"}, 64'(rspAddr), 64'(e[ADDR_W-1:0]));
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [BLK_W-1:0] b);
    return {b, 20'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mTolm = 16'h0C00; mTop = 16'h1000; mBase = 16'h1000; mLimit = 16'h13FF; mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid reset", 64'(rspValid), 64'(0));
    check("R1 cfgErr reset", 64'(cfgErr), 64'(0));
    check("R10 ready idle", 64'(reqReady), 64'(1));
    // R1 reset boundaries seen through routing
    doReq("R1 R3 below 3G", 36'h0_BFF0_0123);
    doReq("R1 R4 at 3G", 36'h0_C000_0000);
    doReq("R1 R7 disabled above 4G", 36'h1_0001_2345);
    @(negedge clk);
    check("R2 idle no rsp", 64'(rspValid), 64'(0));

    // R5 directed translation at base and limit
    cfgWrite(3'd4, 16'h0001);
    doReq("R5 at base", 36'h1_0001_2345);
    check("R5 base value", 64'(rspAddr), 64'h0_C001_2345);
    doReq("R5 at limit", 36'h1_3FFF_FFFF);
    check("R5 limit value", 64'(rspAddr), 64'h0_FFFF_FFFF);
    doReq("R7 above limit", 36'h1_4000_0000);
    // R6 fold past 4G
    cfgWrite(3'd3, 16'h1400);
    doReq("R6 beyond 4G", 36'h1_4000_0010);
    check("R6 target", 64'(rspTarget), 64'h4);
    // R10 unused select ignored
    cfgWrite(3'd7, 16'h0000);
    doReq("R10 unused sel", 36'h1_0000_0000);
    check("R10 still translated", 64'(rspTarget), 64'h1);
    // R8/R9 misaligned tolm
    cfgWrite(3'd0, 16'h0C01);
    check("R8 misaligned err", 64'(cfgErr), 64'(1));
    doReq("R9 err window", 36'h1_0200_0000);
    check("R9 unmapped", 64'(rspTarget), 64'h4);
    cfgWrite(3'd4, 16'h0000);
    check("R8 1MB ok when disabled", 64'(cfgErr), 64'(0));
    cfgWrite(3'd1, 16'h2000);
    doReq("R7 disabled below top", 36'h1_0200_0000);
    check("R7 dram", 64'(rspTarget), 64'h1);
    cfgWrite(3'd2, 16'h1500);
    check("R8 base above limit", 64'(cfgErr), 64'(1));

    // constrained random
    for (int round = 0; round < 60; round++) begin
      logic [BLK_W-1:0] t, bs, lm, tp;
      t = 16'h0400 + 16'($urandom_range(0, 16'h0BFF));
      if ($urandom_range(0, 3) != 0) t = t & 16'hFFC0;
      if (t == 0) t = 16'h0040;
      bs = 16'h1000 + 16'($urandom_range(0, 16'h07FF));
      case ($urandom_range(0, 3))
        0: lm = bs + 16'($urandom_range(0, 16'h01FF)) + (FOURG - t);
        1: lm = bs - 16'($urandom_range(1, 16'h0010));
        default: lm = bs + (FOURG - t) - 16'd1;
      endcase
      tp = lm + 16'($urandom_range(0, 16'h0200));
      cfgWrite(3'd0, t);
      cfgWrite(3'd2, bs);
      cfgWrite(3'd3, lm);
      cfgWrite(3'd1, tp);
      cfgWrite(3'd4, 16'($urandom_range(0, 3) != 0));
      for (int k = 0; k < 12; k++) begin
        logic [BLK_W-1:0] b;
        case ($urandom_range(0, 4))
          0: b = 16'($urandom_range(0, t - 1));
          1: b = t + 16'($urandom_range(0, FOURG - t - 1));
          2: b = bs + 16'($urandom_range(0, 16'h0FFF));
          3: b = ($urandom_range(0, 1) != 0) ? bs : lm;
          default: b = 16'($urandom);
        endcase
        doReq("R3-R9 random", mk(b));
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule